// File: doc/BRIEF.md
# Floppy Sector Read Sequencer

This block runs a floppy read operation once software has armed it. A start pulse begins an operation. A programmable cycle count sets the sector period. At the end of each period the sequencer asks the drive side for the next sector header and copies it into the current-track, current-sector and format registers. Which kind of operation runs is fixed at start by the ID-read enable bit of the interrupt mask.

In ID-read mode, each header only refreshes those registers and raises an ID event. These periods repeat until a stop pulse arrives. In data mode, each period first streams the bytes of the current sector out as a DMA byte stream with valid/ready flow control. After that it fetches the next header and decrements the remaining sector count. When the count runs out, the block goes idle and raises a done event. A first-sector value of 0xFF means no particular sector is wanted: the current-sector register is left alone and a search-any pulse tells the drive to start wherever it is.

The byte data comes from a drive-side read port. The sequencer drives the address as {current sector[6:0], byte index}, and the drive returns the byte on the same cycle.

Top module: `sector_read_seq`

## Requirements
- R1: A start pulse while idle, with stepping not busy, write mode clear and no stop pulse, sets busy on the next cycle.
- R2: A start pulse is ignored if stepping is busy or write mode is set, and busy stays low. A start pulse during a running operation is ignored, so the sector count is not reloaded.
- R3: When an operation starts with first sector not equal to 0xFF, that value appears in the current-sector register on the cycle busy rises. With 0xFF, the register keeps its value and search_any pulses for that one cycle.
- R4: Each consumed header sets current track to {side, track[6:0]}, current sector to {1, sector[6:0]} (bit 7 being the checksum-valid flag), and format to the header's format byte.
- R5: In ID-read mode, each header causes one id_evt pulse and no DMA beat, and the mode repeats until stopped.
- R6: In data mode, each period streams 512 beats. Beat k carries the drive byte at address {current sector[6:0], k[8:0]}, with dma_last on k = 511. Only after the last beat is the next header requested.
- R7: In data mode, sectors_left decrements per header. The header that takes it from 1 to 0 ends the operation: done_evt pulses and busy falls on the same cycle.
- R8: While dma_valid is high and dma_ready is low, dma_valid stays high and address and data hold.
- R9: A stop pulse drops busy, dma_valid and hdr_req on the next cycle, and no later event occurs.
- R10: hdr_req rises exactly period_cycles cycles after busy rises in ID-read mode.
- R11: hdr_req stays high until hdr_valid is seen, and one header is consumed per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_pulse | input | 1 | Request to begin an operation |
| stop_pulse | input | 1 | Request to cancel the operation |
| step_busy | input | 1 | Head stepping in progress |
| wr_mode | input | 1 | Write mode selected |
| id_read_en | input | 1 | ID-read enable bit of the interrupt mask |
| first_sec | input | 8 | First sector register, 0xFF means any |
| sect_count | input | CNT_W | Sectors to transfer, loaded at start |
| period_cycles | input | PER_W | Sector period in clock cycles |
| hdr_req | output | 1 | Header wanted from drive |
| hdr_valid | input | 1 | Header fields valid |
| hdr_side | input | 1 | Header side |
| hdr_track | input | 7 | Header track |
| hdr_sector | input | 7 | Header sector |
| hdr_fmt | input | 8 | Header format byte |
| drv_addr | output | 7+IDX_W | Drive byte address {sector, index} |
| drv_data | input | 8 | Drive byte at drv_addr |
| dma_valid | output | 1 | DMA beat valid |
| dma_data | output | 8 | DMA byte |
| dma_last | output | 1 | Last beat of a sector |
| dma_ready | input | 1 | DMA sink ready |
| busy | output | 1 | Operation running |
| search_any | output | 1 | Start-anywhere pulse |
| id_evt | output | 1 | ID-read event pulse |
| done_evt | output | 1 | Transfer complete pulse |
| cur_track | output | 8 | Current track register |
| cur_sector | output | 8 | Current sector register |
| cur_fmt | output | 8 | Format register |
| sectors_left | output | CNT_W | Remaining sector count |

## Verification
A wrong mode or state bit shows up quickly at the ports. It produces DMA beats in ID-read mode, no id_evt after the next header, or an hdr_req that comes one cycle early or late relative to period_cycles. A wrong byte index or a stale sector register gives a wrong dma_data byte on the very beat where it differs, so the bench compares every beat against its own model. A wrong sector count only shows at the end of the operation, as a missing or extra done_evt and a byte total other than 512 times the count.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_XFER = 2'd2,
    S_HDR  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic       side;
    logic [6:0] track;
    logic [6:0] sector;
    logic [7:0] fmt;
  } sec_hdr_t;

  localparam logic [7:0] ANY_SECTOR = 8'hFF;
endpackage

// File: rtl/seq_period_timer.sv
module seq_period_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             expire
);
  logic [PER_W-1:0] cnt;

  // expires on the period-th cycle of run; a zero period expires at once
  assign expire = run && (({1'b0, cnt} + 1'b1) >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  // R10: counting only happens while running
  p_idle_cnt_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/seq_hdr_regs.sv
module seq_hdr_regs
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load_first,
  input  logic [7:0] first_val,
  input  logic       capture,
  input  sec_hdr_t   hdr,
  output logic [7:0] track_q,
  output logic [7:0] sector_q,
  output logic [7:0] fmt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      track_q  <= '0;
      sector_q <= '0;
      fmt_q    <= '0;
    end else if (capture) begin
      track_q  <= {hdr.side, hdr.track};
      sector_q <= {1'b1, hdr.sector};
      fmt_q    <= hdr.fmt;
    end else if (load_first) begin
      sector_q <= first_val;
    end
  end

  // R4: a captured header always carries the checksum-valid flag
  p_sector_valid_r4: assert property (@(posedge clk) disable iff (rst)
    capture |=> sector_q[7]);
endmodule

// File: rtl/sector_read_seq.sv
module sector_read_seq
  import seq_pkg::*;
#(
  parameter int SECT_BYTES = 512,
  parameter int PER_W      = 16,
  parameter int CNT_W      = 8,
  localparam int IDX_W     = $clog2(SECT_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_pulse,
  input  logic             stop_pulse,
  input  logic             step_busy,
  input  logic             wr_mode,
  input  logic             id_read_en,
  input  logic [7:0]       first_sec,
  input  logic [CNT_W-1:0] sect_count,
  input  logic [PER_W-1:0] period_cycles,
  output logic             hdr_req,
  input  logic             hdr_valid,
  input  logic             hdr_side,
  input  logic [6:0]       hdr_track,
  input  logic [6:0]       hdr_sector,
  input  logic [7:0]       hdr_fmt,
  output logic [6+IDX_W:0] drv_addr,
  input  logic [7:0]       drv_data,
  output logic             dma_valid,
  output logic [7:0]       dma_data,
  output logic             dma_last,
  input  logic             dma_ready,
  output logic             busy,
  output logic             search_any,
  output logic             id_evt,
  output logic             done_evt,
  output logic [7:0]       cur_track,
  output logic [7:0]       cur_sector,
  output logic [7:0]       cur_fmt,
  output logic [CNT_W-1:0] sectors_left
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECT_BYTES - 1);

  seq_state_e       st;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt_q;
  logic             id_mode;
  logic             expire;
  logic             start_ok;
  logic             load_first;
  logic             capture;
  sec_hdr_t         hdr_in;

  assign start_ok   = (st == S_IDLE) && start_pulse && !stop_pulse && !step_busy && !wr_mode;
  assign load_first = start_ok && (first_sec != ANY_SECTOR);
  assign capture    = (st == S_HDR) && hdr_valid && !stop_pulse;
  assign hdr_in     = '{side: hdr_side, track: hdr_track, sector: hdr_sector, fmt: hdr_fmt};

  seq_period_timer #(.PER_W(PER_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (st == S_WAIT),
    .period (period_cycles),
    .expire (expire)
  );

  seq_hdr_regs u_hdr (
    .clk        (clk),
    .rst        (rst),
    .load_first (load_first),
    .first_val  (first_sec),
    .capture    (capture),
    .hdr        (hdr_in),
    .track_q    (cur_track),
    .sector_q   (cur_sector),
    .fmt_q      (cur_fmt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      idx        <= '0;
      cnt_q      <= '0;
      id_mode    <= 1'b0;
      id_evt     <= 1'b0;
      done_evt   <= 1'b0;
      search_any <= 1'b0;
    end else begin
      id_evt     <= 1'b0;
      done_evt   <= 1'b0;
      search_any <= 1'b0;
      if (stop_pulse) begin
        st <= S_IDLE;
      end else begin
        unique case (st)
          S_IDLE: if (start_ok) begin
            st         <= S_WAIT;
            id_mode    <= id_read_en;
            cnt_q      <= sect_count;
            search_any <= (first_sec == ANY_SECTOR);
          end
          S_WAIT: if (expire) begin
            idx <= '0;
            st  <= id_mode ? S_HDR : S_XFER;
          end
          S_XFER: if (dma_ready) begin
            if (idx == LAST_IDX) st <= S_HDR;
            else                 idx <= idx + 1'b1;
          end
          S_HDR: if (hdr_valid) begin
            if (id_mode) begin
              id_evt <= 1'b1;
              st     <= S_WAIT;
            end else begin
              cnt_q <= cnt_q - 1'b1;
              if (cnt_q == CNT_W'(1)) begin
                done_evt <= 1'b1;
                st       <= S_IDLE;
              end else begin
                st <= S_WAIT;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign busy         = (st != S_IDLE);
  assign hdr_req      = (st == S_HDR);
  assign dma_valid    = (st == S_XFER);
  assign dma_last     = dma_valid && (idx == LAST_IDX);
  assign drv_addr     = {cur_sector[6:0], idx};
  assign dma_data     = drv_data;
  assign sectors_left = cnt_q;

  // R1: an allowed start takes effect on the next cycle
  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_pulse && !stop_pulse && !step_busy && !wr_mode) |=> busy);
  // R2: blocked start leaves the block idle
  p_start_blocked_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_pulse && (step_busy || wr_mode)) |=> !busy);
  // R5: the two events never coincide
  p_evt_excl_r5: assert property (@(posedge clk) disable iff (rst)
    id_evt |-> !done_evt);
  // R7: completion leaves the block idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done_evt |-> (!busy && sectors_left == '0));
  // R8: a stalled beat holds
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (dma_valid && !dma_ready && !stop_pulse) |=> (dma_valid && $stable(drv_addr)));
  // R9: stop empties every request
  p_stop_r9: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |=> (!busy && !dma_valid && !hdr_req));
  // R11: header request held until answered
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (hdr_req && !hdr_valid && !stop_pulse) |=> hdr_req);
endmodule

// File: tb/test_sector_read_seq.sv
module test_sector_read_seq;
  localparam int IDX_W = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_pulse = 1'b0, stop_pulse = 1'b0, step_busy = 1'b0, wr_mode = 1'b0;
  logic id_read_en = 1'b0;
  logic [7:0] first_sec = 8'hFF;
  logic [7:0] sect_count = 8'd1;
  logic [15:0] period_cycles = 16'd4;
  logic hdr_req, hdr_valid = 1'b0, hdr_side = 1'b0;
  logic [6:0] hdr_track = '0, hdr_sector = '0;
  logic [7:0] hdr_fmt = '0;
  logic [6+IDX_W:0] drv_addr;
  logic [7:0] drv_data;
  logic dma_valid, dma_last, dma_ready = 1'b0;
  logic [7:0] dma_data;
  logic busy, search_any, id_evt, done_evt;
  logic [7:0] cur_track, cur_sector, cur_fmt, sectors_left;

  int checks = 0, failures = 0;
  int hdr_cnt = 0, id_cnt = 0, done_cnt = 0, byte_cnt = 0;
  int byte_err = 0, stall_err = 0, hdr_err = 0, last_err = 0;
  int rdy_mode = 0;
  logic busy_q = 1'b0;
  logic [6:0] exp_sec = '0;
  logic [8:0] bidx = '0;
  logic stall_q = 1'b0;
  logic [7:0] stall_data = '0;

  always #10 clk = ~clk;

  function automatic logic [7:0] fexp(logic [6:0] s, logic [8:0] i);
    return i[7:0] ^ {s, 1'b0} ^ {7'b0, i[8]};
  endfunction

  assign drv_data = fexp(drv_addr[15:9], drv_addr[8:0]);

  sector_read_seq i_sector_read_seq (
    .clk(clk), .rst(rst), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .step_busy(step_busy), .wr_mode(wr_mode), .id_read_en(id_read_en),
    .first_sec(first_sec), .sect_count(sect_count), .period_cycles(period_cycles),
    .hdr_req(hdr_req), .hdr_valid(hdr_valid), .hdr_side(hdr_side),
    .hdr_track(hdr_track), .hdr_sector(hdr_sector), .hdr_fmt(hdr_fmt),
    .drv_addr(drv_addr), .drv_data(drv_data), .dma_valid(dma_valid),
    .dma_data(dma_data), .dma_last(dma_last), .dma_ready(dma_ready),
    .busy(busy), .search_any(search_any), .id_evt(id_evt), .done_evt(done_evt),
    .cur_track(cur_track), .cur_sector(cur_sector), .cur_fmt(cur_fmt),
    .sectors_left(sectors_left)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drive model and DMA sink monitor, all at the falling edge
  always @(negedge clk) begin
    if (hdr_valid) begin
      // consumed at the previous rising edge (R11): registers hold it now (R4)
      hdr_valid = 1'b0;
      hdr_cnt++;
      if (cur_track != {hdr_side, hdr_track} || cur_sector != {1'b1, hdr_sector} ||
          cur_fmt != hdr_fmt) hdr_err++;
      exp_sec = hdr_sector;
      bidx = '0;
    end else if (hdr_req && ($urandom % 3 == 0)) begin
      hdr_side   = 1'($urandom);
      hdr_track  = 7'($urandom);
      hdr_sector = 7'($urandom);
      hdr_fmt    = 8'($urandom);
      hdr_valid  = 1'b1;
    end
    if (busy && !busy_q) begin
      exp_sec = cur_sector[6:0];
      bidx = '0;
    end
    busy_q = busy;
    if (id_evt) id_cnt++;
    if (done_evt) done_cnt++;
    // R8: a stalled beat must still be there with the same byte
    if (stall_q && !stop_pulse && (!dma_valid || dma_data != stall_data)) stall_err++;
    dma_ready = (rdy_mode == 1) ? 1'b1 : 1'($urandom % 2);
    stall_q = dma_valid && !dma_ready;
    stall_data = dma_data;
    if (dma_valid && dma_ready) begin
      byte_cnt++;
      if (dma_data != fexp(exp_sec, bidx)) byte_err++;
      if (dma_last != (bidx == 9'd511)) last_err++;
      bidx = bidx + 1'b1;
    end
  end

  task automatic pulse_start();
    start_pulse = 1'b1;
    @(negedge clk);
    start_pulse = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_pulse = 1'b1;
    @(negedge clk);
    stop_pulse = 1'b0;
  endtask

  task automatic run_data(input logic [7:0] fs, input int n, input int per);
    int b0, d0, h0, e0, s0, l0;
    id_read_en = 1'b0; first_sec = fs; sect_count = 8'(n); period_cycles = 16'(per);
    b0 = byte_cnt; d0 = done_cnt; h0 = hdr_cnt; e0 = byte_err; s0 = stall_err; l0 = last_err;
    pulse_start();
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    for (int k = 0; k < 40000 && done_cnt == d0; k++) @(negedge clk);
    chk(done_cnt - d0 == 1, "R7 one done event", done_cnt - d0, 1);
    chk(busy == 1'b0 && sectors_left == 8'd0, "R7 idle with zero count", int'(sectors_left), 0);
    chk(byte_cnt - b0 == 512 * n, "R6 byte total", byte_cnt - b0, 512 * n);
    chk(hdr_cnt - h0 == n, "R11 headers per sector", hdr_cnt - h0, n);
    chk(byte_err == e0 && last_err == l0, "R6 byte content", byte_err - e0, 0);
    chk(stall_err == s0, "R8 stall hold", stall_err - s0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 act=timeout exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, i0, d0, h0, b0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !hdr_req && !dma_valid && !id_evt && !done_evt, "R1 reset idle", int'(busy), 0);
    chk(cur_sector == 8'd0 && cur_track == 8'd0, "R4 reset registers", int'(cur_sector), 0);

    // R2 blocked starts
    wr_mode = 1'b1; pulse_start(); @(negedge clk);
    chk(busy == 1'b0, "R2 start ignored in write mode", int'(busy), 0);
    wr_mode = 1'b0; step_busy = 1'b1; pulse_start(); @(negedge clk);
    chk(busy == 1'b0, "R2 start ignored while stepping", int'(busy), 0);
    step_busy = 1'b0;

    // ID-read mode with any-sector search
    id_read_en = 1'b1; first_sec = 8'hFF; period_cycles = 16'd5;
    b0 = byte_cnt; i0 = id_cnt;
    pulse_start();
    chk(search_any == 1'b1, "R3 search_any pulse", int'(search_any), 1);
    chk(cur_sector == 8'd0, "R3 sector kept on 0xFF", int'(cur_sector), 0);
    n = 0;
    for (int k = 0; k < 100 && !hdr_req; k++) begin @(negedge clk); n++; end
    chk(n == 5, "R10 period to first request", n, 5);
    for (int k = 0; k < 2000 && id_cnt < i0 + 3; k++) @(negedge clk);
    chk(id_cnt - i0 == 3, "R5 id events repeat", id_cnt - i0, 3);
    chk(byte_cnt == b0, "R5 no DMA in ID mode", byte_cnt - b0, 0);
    chk(hdr_err == 0, "R4 header packing", hdr_err, 0);
    chk(busy == 1'b1, "R5 still running", int'(busy), 1);
    pulse_stop();
    chk(!busy && !hdr_req && !dma_valid, "R9 stop in ID mode", int'(busy), 0);
    i0 = id_cnt; d0 = done_cnt;
    repeat (30) @(negedge clk);
    chk(id_cnt == i0 && done_cnt == d0, "R9 no events after stop", id_cnt - i0, 0);

    // data mode, first sector loaded; second start mid-run ignored (R2)
    id_read_en = 1'b0; first_sec = 8'h12; sect_count = 8'd2; period_cycles = 16'd3;
    d0 = done_cnt; h0 = hdr_cnt; b0 = byte_cnt;
    pulse_start();
    chk(cur_sector == 8'h12, "R3 first sector loaded", int'(cur_sector), 8'h12);
    chk(sectors_left == 8'd2, "R7 count loaded", int'(sectors_left), 2);
    repeat (40) @(negedge clk);
    sect_count = 8'd5; pulse_start();
    for (int k = 0; k < 40000 && done_cnt == d0; k++) @(negedge clk);
    chk(hdr_cnt - h0 == 2, "R2 restart ignored while busy", hdr_cnt - h0, 2);
    chk(byte_cnt - b0 == 1024, "R6 two sectors", byte_cnt - b0, 1024);
    chk(byte_err == 0 && last_err == 0, "R6 bytes and last flag", byte_err, 0);
    chk(stall_err == 0, "R8 stall hold", stall_err, 0);

    // stop in the middle of a transfer
    first_sec = 8'h05; sect_count = 8'd3; d0 = done_cnt;
    pulse_start();
    for (int k = 0; k < 1000 && !dma_valid; k++) @(negedge clk);
    repeat (50) @(negedge clk);
    pulse_stop();
    chk(!busy && !dma_valid, "R9 stop during transfer", int'(dma_valid), 0);
    repeat (30) @(negedge clk);
    chk(done_cnt == d0 && !dma_valid, "R9 no done after stop", done_cnt - d0, 0);

    // full-rate sink, then random operations
    rdy_mode = 1;
    run_data(8'h7E, 1, 1);
    rdy_mode = 0;
    for (int it = 0; it < 4; it++) begin
      run_data(($urandom % 4 == 0) ? 8'hFF : 8'($urandom % 128),
               1 + int'($urandom % 2), 1 + int'($urandom % 8));
    end
    chk(hdr_err == 0, "R4 header packing overall", hdr_err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule